// File: doc/BRIEF.md
# Programmed I/O Device Port

This block is the device side of a 16-bit processor I/O channel for transfers under direct program control. An outbound tag marks a program-control sequence. While the tag is high, the address bus carries the first command word and the data bus carries the second. The block checks whether the device is selected and reads the transfer direction from the command word.

On a write or control sequence, the block latches the data word at the first cycle of the tag. It checks odd parity on each byte. It then gives one strobe together with the six-bit command code. On a read sequence, it drives the device's read word onto the bus with freshly generated parity, and only for as long as the tag lasts.

A strap input selects byte-oriented operation. In that mode, the high data byte is neither checked nor passed on for writes, and it is driven as zero on reads. Bus bits are numbered from 0, which is the most significant bit.

Top module: `pio_dev_port`

## Requirements
- R1: The device is selected when address bus bits 8–15 equal `dev_addr_i`. Address bit 0 (channel select) has no effect on selection, and an unselected sequence produces no strobe, no error and no bus drive.
- R2: On the first cycle the tag is sampled high, a selected sequence with address bit 1 = 1 is a write. If parity passes, `wr_stb_o` is high in the next cycle for exactly one cycle. In that cycle `wr_data_o` equals the data bus word and `cmd_o` equals address bits 2–7, with bit 2 as the MSB of `cmd_o`.
- R3: Parity is odd per byte. `par_i[0]` covers data bits 0–7 and `par_i[1]` covers data bits 8–15. A write whose checked bytes fail parity pulses `par_err_o` for one cycle, in the slot where the strobe would have been, and gives no strobe.
- R4: With `byte_mode_i` = 1, a write ignores the parity of data bits 0–7, still checks bits 8–15, and delivers bits 0–7 of `wr_data_o` as zero.
- R5: `data_oe_o` is high exactly while the tag is high, the device is selected and address bit 1 = 0. While it is high, `data_o` equals `rd_data_i` and each bit of `par_o` gives odd parity over its byte.
- R6: With `byte_mode_i` = 1, a read drives data bits 0–7 as zero with `par_o[0]` = 1, and drives bits 8–15 from `rd_data_i`.
- R7: When the block is not driving, `data_oe_o` is 0 and `data_o` and `par_o` are all zero. This includes the time during write sequences.
- R8: A tag held high for several cycles gives at most one strobe or error per sequence.
- R9: During and after synchronous reset, `wr_stb_o`, `par_err_o`, `wr_data_o` and `cmd_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr_i | input | 8 | This device's address |
| byte_mode_i | input | 1 | Byte-oriented strap |
| tag_i | input | 1 | Program-control sequence tag |
| addr_i | input | 16 | Address bus, first command word |
| data_i | input | 16 | Data bus inbound |
| par_i | input | 2 | Inbound odd parity per byte |
| rd_data_i | input | 16 | Device read word |
| data_o | output | 16 | Data bus outbound |
| par_o | output | 2 | Outbound odd parity per byte |
| data_oe_o | output | 1 | Outbound drive enable |
| wr_stb_o | output | 1 | One-cycle write/control strobe |
| par_err_o | output | 1 | One-cycle parity error pulse |
| wr_data_o | output | 16 | Captured write word |
| cmd_o | output | 6 | Command code from address bits 2–7 |

## Verification
Writes are tried with clean parity, with a bad high-byte parity bit and with a bad low-byte parity bit. The same faults are then repeated in byte mode, which shows which byte each parity bit guards and which checks the strap turns off. Address patterns flip the channel-select bit, use a foreign device number and switch the direction bit, which separates selection from direction. Reads are run in word and byte mode and compared with sequences the block must not drive. A tag held over several cycles checks that a sequence yields a single strobe.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int BUS_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = BUS_W / BYTE_W;
    localparam int DIR_BIT = 1;
    localparam int CMD_LO  = 2;
    localparam int CMD_HI  = 7;
    localparam int CMD_W   = CMD_HI - CMD_LO + 1;
    localparam int DEV_LO  = CMD_HI + 1;
    localparam int DEV_W   = BUS_W - DEV_LO;

    typedef logic [0:BUS_W-1]  word_t;
    typedef logic [0:BYTE_W-1] byte_t;
    typedef logic [0:NBYTES-1] par_t;
    typedef logic [0:CMD_W-1]  cmd_t;
    typedef logic [0:DEV_W-1]  dev_t;

    typedef struct packed {
        logic sel;
        logic is_write;
        logic wr_start;
        logic rd_active;
    } decode_t;

    typedef struct packed {
        cmd_t  cmd;
        word_t data;
    } wr_word_t;

    function automatic logic odd_par(input byte_t b);
        return ~^b;
    endfunction

    function automatic byte_t byte_of(input word_t w, input int idx);
        return w[idx*BYTE_W +: BYTE_W];
    endfunction
endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
(
    input  logic    tag,
    input  logic    tag_q,
    input  word_t   addr,
    input  dev_t    dev_addr,
    output decode_t dec
);
    always_comb begin
        dec.sel       = (addr[DEV_LO +: DEV_W] == dev_addr);
        dec.is_write  = addr[DIR_BIT];
        dec.wr_start  = tag && !tag_q && dec.sel && dec.is_write;
        dec.rd_active = tag && dec.sel && !dec.is_write;
    end
endmodule

// File: rtl/pio_wr_capture.sv
module pio_wr_capture
    import pio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     byte_mode,
    input  cmd_t     cmd_in,
    input  word_t    data_in,
    input  par_t     par_in,
    output logic     stb,
    output logic     err,
    output wr_word_t word_q
);
    par_t  ok_byte;
    logic  all_ok;
    word_t masked;

    for (genvar i = 0; i < NBYTES; i++) begin : g_chk
        if (i < NBYTES - 1) begin : g_hi
            assign ok_byte[i] = byte_mode || (odd_par(byte_of(data_in, i)) == par_in[i]);
            assign masked[i*BYTE_W +: BYTE_W] = byte_mode ? '0 : byte_of(data_in, i);
        end else begin : g_lo
            assign ok_byte[i] = (odd_par(byte_of(data_in, i)) == par_in[i]);
            assign masked[i*BYTE_W +: BYTE_W] = byte_of(data_in, i);
        end
    end

    assign all_ok = &ok_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb    <= 1'b0;
            err    <= 1'b0;
            word_q <= '0;
        end else begin
            stb <= start && all_ok;
            err <= start && !all_ok;
            if (start && all_ok) begin
                word_q.cmd  <= cmd_in;
                word_q.data <= masked;
            end
        end
    end
endmodule

// File: rtl/pio_rd_drive.sv
module pio_rd_drive
    import pio_pkg::*;
(
    input  logic  active,
    input  logic  byte_mode,
    input  word_t rd_data,
    output word_t data_out,
    output par_t  par_out,
    output logic  oe
);
    word_t shaped;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        if (i < NBYTES - 1) begin : g_hi
            assign shaped[i*BYTE_W +: BYTE_W] = byte_mode ? '0 : byte_of(rd_data, i);
        end else begin : g_lo
            assign shaped[i*BYTE_W +: BYTE_W] = byte_of(rd_data, i);
        end
        assign par_out[i] = active && odd_par(byte_of(shaped, i));
    end

    assign data_out = active ? shaped : '0;
    assign oe       = active;
endmodule

// File: rtl/pio_dev_port.sv
module pio_dev_port
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [0:DEV_W-1]  dev_addr_i,
    input  logic              byte_mode_i,
    input  logic              tag_i,
    input  logic [0:BUS_W-1]  addr_i,
    input  logic [0:BUS_W-1]  data_i,
    input  logic [0:NBYTES-1] par_i,
    input  logic [0:BUS_W-1]  rd_data_i,
    output logic [0:BUS_W-1]  data_o,
    output logic [0:NBYTES-1] par_o,
    output logic              data_oe_o,
    output logic              wr_stb_o,
    output logic              par_err_o,
    output logic [0:BUS_W-1]  wr_data_o,
    output logic [0:CMD_W-1]  cmd_o
);
    logic     tag_q;
    decode_t  dec;
    wr_word_t wq;

    always_ff @(posedge clk) begin
        if (rst) tag_q <= 1'b0;
        else     tag_q <= tag_i;
    end

    pio_decode u_dec (
        .tag      (tag_i),
        .tag_q    (tag_q),
        .addr     (addr_i),
        .dev_addr (dev_addr_i),
        .dec      (dec)
    );

    pio_wr_capture u_wr (
        .clk       (clk),
        .rst       (rst),
        .start     (dec.wr_start),
        .byte_mode (byte_mode_i),
        .cmd_in    (addr_i[CMD_LO +: CMD_W]),
        .data_in   (data_i),
        .par_in    (par_i),
        .stb       (wr_stb_o),
        .err       (par_err_o),
        .word_q    (wq)
    );

    pio_rd_drive u_rd (
        .active    (dec.rd_active),
        .byte_mode (byte_mode_i),
        .rd_data   (rd_data_i),
        .data_out  (data_o),
        .par_out   (par_o),
        .oe        (data_oe_o)
    );

    assign wr_data_o = wq.data;
    assign cmd_o     = wq.cmd;
endmodule

// File: rtl/pio_dev_port_chk.sv
module pio_dev_port_chk
    import pio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [0:DEV_W-1]  dev_addr_i,
    input logic              byte_mode_i,
    input logic              tag_i,
    input logic [0:BUS_W-1]  addr_i,
    input logic [0:BUS_W-1]  data_o,
    input logic [0:NBYTES-1] par_o,
    input logic              data_oe_o,
    input logic              wr_stb_o,
    input logic              par_err_o,
    input logic [0:BUS_W-1]  wr_data_o
);
    assert_one_cycle_stb_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> !wr_stb_o);

    assert_stb_after_write_tag_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> $past(tag_i) && $past(addr_i[DIR_BIT]));

    assert_err_excludes_stb_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb_o && par_err_o));

    assert_single_event_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_stb_o || par_err_o) |=> !(wr_stb_o || par_err_o));

    assert_byte_write_high_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_stb_o && $past(byte_mode_i)) |-> (wr_data_o[0:BYTE_W-1] == '0));

    assert_oe_only_read_R5: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> (tag_i && !addr_i[DIR_BIT] && addr_i[DEV_LO +: DEV_W] == dev_addr_i));

    assert_low_byte_odd_R5: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> (^{data_o[BUS_W-BYTE_W +: BYTE_W], par_o[NBYTES-1]}));

    assert_byte_read_R6: assert property (@(posedge clk) disable iff (rst)
        (data_oe_o && byte_mode_i) |-> (data_o[0:BYTE_W-1] == '0 && par_o[0]));

    assert_released_R7: assert property (@(posedge clk) disable iff (rst)
        !data_oe_o |-> (data_o == '0 && par_o == '0));
endmodule

bind pio_dev_port pio_dev_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .dev_addr_i  (dev_addr_i),
    .byte_mode_i (byte_mode_i),
    .tag_i       (tag_i),
    .addr_i      (addr_i),
    .data_o      (data_o),
    .par_o       (par_o),
    .data_oe_o   (data_oe_o),
    .wr_stb_o    (wr_stb_o),
    .par_err_o   (par_err_o),
    .wr_data_o   (wr_data_o)
);

// File: tb/tb_pio_dev_port.sv
`timescale 1ns/1ps
module tb_pio_dev_port;
    logic        clk = 1'b0;
    logic        rst;
    logic [0:7]  dev_addr_i;
    logic        byte_mode_i;
    logic        tag_i;
    logic [0:15] addr_i, data_i, rd_data_i;
    logic [0:1]  par_i;
    logic [0:15] data_o, wr_data_o;
    logic [0:1]  par_o;
    logic        data_oe_o, wr_stb_o, par_err_o;
    logic [0:5]  cmd_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pio_dev_port dut (.*);

    localparam logic [0:7] MY_DEV = 8'h3C;

    function automatic logic op(input logic [0:7] b);
        return ~^b;
    endfunction

    function automatic logic [0:15] mk_addr(input logic ch, input logic wr,
                                            input logic [0:5] cmd, input logic [0:7] dev);
        return {ch, wr, cmd, dev};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        tag_i = 1'b0; addr_i = '0; data_i = '0; par_i = '0;
    endtask

    // Write sequence; expects strobe or error one cycle after the first tag cycle.
    task automatic do_write(input string req, input logic [0:15] addr, input logic [0:15] d,
                            input logic [0:1] p, input logic exp_stb, input logic exp_err,
                            input logic [0:15] exp_data);
        @(negedge clk);
        addr_i = addr; data_i = d; par_i = p; tag_i = 1'b1;
        #1 check(req, "oe during write (R7)", {31'd0, data_oe_o}, 32'd0);
        @(negedge clk);
        check(req, "wr_stb", {31'd0, wr_stb_o}, {31'd0, exp_stb});
        check(req, "par_err", {31'd0, par_err_o}, {31'd0, exp_err});
        if (exp_stb) begin
            check(req, "wr_data", {16'd0, wr_data_o}, {16'd0, exp_data});
            check(req, "cmd", {26'd0, cmd_o}, {26'd0, addr[2:7]});
        end
        @(negedge clk);
        check("R8", "second cycle stb/err", {30'd0, wr_stb_o, par_err_o}, 32'd0);
        @(negedge clk);
        check("R8", "third cycle stb/err", {30'd0, wr_stb_o, par_err_o}, 32'd0);
        idle();
    endtask

    task automatic do_read(input string req, input logic [0:15] addr, input logic [0:15] rd,
                           input logic exp_oe, input logic [0:15] exp_d);
        logic [0:1] exp_p;
        exp_p = exp_oe ? {op(exp_d[0:7]), op(exp_d[8:15])} : 2'b00;
        @(negedge clk);
        addr_i = addr; rd_data_i = rd; tag_i = 1'b1;
        #1;
        check(req, "data_oe", {31'd0, data_oe_o}, {31'd0, exp_oe});
        check(req, "data_o", {16'd0, data_o}, {16'd0, exp_d});
        check(req, "par_o", {30'd0, par_o}, {30'd0, exp_p});
        @(negedge clk);
        check("R7", "no write event on read", {30'd0, wr_stb_o, par_err_o}, 32'd0);
        tag_i = 1'b0;
        #1;
        check("R7", "released after tag", {13'd0, data_oe_o, par_o, data_o}, 32'd0);
        idle();
    endtask

    task automatic t_reset();
        rst = 1'b1; idle(); dev_addr_i = MY_DEV; byte_mode_i = 1'b0; rd_data_i = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R9", "reset outputs", {8'd0, wr_stb_o, par_err_o, cmd_o, wr_data_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "after reset", {8'd0, wr_stb_o, par_err_o, cmd_o, wr_data_o}, 32'd0);
    endtask

    task automatic t_word_writes();
        logic [0:15] d;
        d = 16'hA55B;
        do_write("R2", mk_addr(0, 1, 6'h2D, MY_DEV), d, {op(d[0:7]), op(d[8:15])}, 1, 0, d);
        d = 16'h0F13;
        do_write("R1", mk_addr(1, 1, 6'h11, MY_DEV), d, {op(d[0:7]), op(d[8:15])}, 1, 0, d);
        do_write("R3", mk_addr(0, 1, 6'h05, MY_DEV), d, {~op(d[0:7]), op(d[8:15])}, 0, 1, d);
        check("R3", "cmd unchanged after error", {26'd0, cmd_o}, {26'd0, 6'h11});
        do_write("R3", mk_addr(0, 1, 6'h05, MY_DEV), d, {op(d[0:7]), ~op(d[8:15])}, 0, 1, d);
        do_write("R1", mk_addr(0, 1, 6'h05, 8'h3D), d, {op(d[0:7]), op(d[8:15])}, 0, 0, d);
        do_write("R1", mk_addr(0, 1, 6'h05, 8'h3D), d, 2'b00, 0, 0, d);
    endtask

    task automatic t_byte_writes();
        logic [0:15] d;
        byte_mode_i = 1'b1;
        d = 16'h7E81;
        do_write("R4", mk_addr(0, 1, 6'h3F, MY_DEV), d, {~op(d[0:7]), op(d[8:15])}, 1, 0,
                 {8'h00, d[8:15]});
        do_write("R4", mk_addr(0, 1, 6'h01, MY_DEV), d, {op(d[0:7]), ~op(d[8:15])}, 0, 1, d);
        byte_mode_i = 1'b0;
    endtask

    task automatic t_reads();
        do_read("R5", mk_addr(0, 0, 6'h0A, MY_DEV), 16'hC3A7, 1, 16'hC3A7);
        do_read("R5", mk_addr(1, 0, 6'h0A, MY_DEV), 16'h0001, 1, 16'h0001);
        do_read("R7", mk_addr(0, 0, 6'h0A, 8'h00), 16'hC3A7, 0, 16'h0000);
        byte_mode_i = 1'b1;
        do_read("R6", mk_addr(0, 0, 6'h0A, MY_DEV), 16'hFF5C, 1, 16'h005C);
        byte_mode_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_word_writes();
        t_byte_writes();
        t_reads();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule